// File: doc/BRIEF.md
# ADC conversion trigger arbiter

This block gathers flags raised by timer event sources and turns each one into exactly one conversion request toward an ADC. Every event input owns a small configuration register. Software writes it through a synchronous address/data port. The register names the ADC channel to convert when that event fires. For inputs fed by periodic timers, the register also carries a force-acknowledge bit.

When several flags are pending, the lowest-numbered event wins. The block latches that event's channel code and raises a request toward the ADC. It holds the request until the ADC signals ready. In that same handshake cycle it pulses an acknowledge back to the winning source so the source can clear its flag. It then returns to arbitration. Only one request is outstanding at any time.

A set force bit holds that input's acknowledge high permanently. It also removes the input from arbitration, which lets software drain a timer flag without spending a conversion.

Top module: `adc_trig_arb`

## Requirements
- R1: After reset every configuration register reads zero, `adc_req_o` is low and `evt_ack_o` is all zero.
- R2: A write stores `reg_wdata_i` into the register selected by `reg_addr_i`. Bits 6:0 hold the channel field and bit 7 holds the force bit. `reg_rdata_o` shows the register addressed in the previous cycle.
- R3: The force bit can be stored only on inputs whose bit is set in `FORCE_MASK`. On any other input, bit 7 always reads 0 and has no effect on the acknowledge.
- R4: When more than one non-forced flag is pending at arbitration time, the request is issued for the lowest pending index.
- R5: `adc_chan_o` carries the channel field of the granted event unchanged: field value n requests ADC channel n.
- R6: While `adc_req_o` is high and `adc_rdy_i` is low, `adc_req_o` stays high and `adc_chan_o` stays stable in the next cycle.
- R7: In the cycle where `adc_req_o` and `adc_rdy_i` are both high, `evt_ack_o` has the granted index set. Apart from forced inputs, no other bit is set. Outside handshake cycles, only forced inputs show an acknowledge.
- R8: A flag that is still high in the cycle after its acknowledge is arbitrated again and produces a new request.
- R9: An input whose force bit is set has its acknowledge held high continuously and is never granted a request.
- R10: The cycle after a handshake has `adc_req_o` low, so at most one request is in flight.
- R11: The channel code is captured at grant time. A register write during an open request does not change `adc_chan_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | $clog2(N_EVT) | Register index for read and write |
| reg_wdata_i | input | CH_W+1 | Write data: force bit over channel field |
| reg_rdata_o | output | CH_W+1 | Registered read data |
| evt_flag_i | input | N_EVT | Pending event flags from timers |
| evt_ack_o | output | N_EVT | Acknowledge to event sources |
| adc_req_o | output | 1 | Conversion request to ADC |
| adc_chan_o | output | CH_W | Channel code for the request |
| adc_rdy_i | input | 1 | ADC ready; request accepted when high with req |

## Verification
The bench builds the block with eight event inputs and a seven-bit channel field. `FORCE_MASK` is 8'h0C, so inputs 2 and 3 carry a force bit and the rest do not. This small setup lets every event index be reached directly and makes the priority order easy to check. It also lets both kinds of input be used in the same run: software forces input 2 while a non-forceable input still wins arbitration, and a write of bit 7 to input 0 is shown to be dropped.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/adc_trig_prio.sv
// Fixed priority pick: lowest set index wins.
module adc_trig_prio #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_trig_cfg.sv
// Per-event configuration: channel field plus optional force bit.
module adc_trig_cfg #(
  parameter int              N_EVT      = 64,
  parameter int              CH_W       = 7,
  parameter int              ADDR_W     = $clog2(N_EVT),
  parameter logic [N_EVT-1:0] FORCE_MASK = '0,
  localparam int             DW         = CH_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  output logic [N_EVT-1:0][CH_W-1:0]  chan_o,
  output logic [N_EVT-1:0]            clr_o
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    logic sel;
    assign sel = we_i && (addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  chan_o[i] <= '0;
      else if (sel) chan_o[i] <= wdata_i[CH_W-1:0];
    end

    if (FORCE_MASK[i]) begin : g_force
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  clr_o[i] <= 1'b0;
        else if (sel) clr_o[i] <= wdata_i[CH_W];
      end
    end else begin : g_noforce
      assign clr_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= {clr_o[addr_i], chan_o[addr_i]};
  end
endmodule

// File: rtl/adc_trig_arb.sv
module adc_trig_arb
  import adc_trig_pkg::*;
#(
  parameter int               N_EVT      = 64,
  parameter int               CH_W       = 7,
  parameter logic [N_EVT-1:0] FORCE_MASK = N_EVT'(8'hFF),
  localparam int              IDX_W      = $clog2(N_EVT),
  localparam int              DW         = CH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [N_EVT-1:0]  evt_flag_i,
  output logic [N_EVT-1:0]  evt_ack_o,
  output logic              adc_req_o,
  output logic [CH_W-1:0]   adc_chan_o,
  input  logic              adc_rdy_i
);
  logic [N_EVT-1:0][CH_W-1:0] chan_tbl;
  logic [N_EVT-1:0]           clr_vec;
  logic [N_EVT-1:0]           pend;
  logic                       pick_vld;
  logic [IDX_W-1:0]           pick_idx;
  logic [IDX_W-1:0]           sel_q;
  logic [CH_W-1:0]            chan_q;
  arb_state_e                 state_q;

  adc_trig_cfg #(
    .N_EVT(N_EVT), .CH_W(CH_W), .ADDR_W(IDX_W), .FORCE_MASK(FORCE_MASK)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .chan_o  (chan_tbl),
    .clr_o   (clr_vec)
  );

  // forced inputs never compete
  assign pend = evt_flag_i & ~clr_vec;

  adc_trig_prio #(.N(N_EVT), .IDX_W(IDX_W)) u_prio (
    .req_i (pend),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pick_vld) begin
          sel_q   <= pick_idx;
          chan_q  <= chan_tbl[pick_idx];
          state_q <= ST_BUSY;
        end
        ST_BUSY: if (adc_rdy_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_req_o  = (state_q == ST_BUSY);
  assign adc_chan_o = chan_q;

  // ack in the handshake cycle so the source drops its flag at the same edge
  always_comb begin
    evt_ack_o = clr_vec;
    if (adc_req_o && adc_rdy_i) evt_ack_o[sel_q] = 1'b1;
  end
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
  parameter int N_EVT = 64,
  parameter int CH_W  = 7,
  localparam int IDX_W = $clog2(N_EVT)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_req_o,
  input logic              adc_rdy_i,
  input logic [CH_W-1:0]   adc_chan_o,
  input logic [N_EVT-1:0]  evt_ack_o,
  input logic [N_EVT-1:0]  clr_vec,
  input logic [IDX_W-1:0]  sel_q
);
  logic [N_EVT-1:0] clr_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_d <= '0;
    else         clr_d <= clr_vec;
  end

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_rdy_i |=> adc_req_o && $stable(adc_chan_o));

  // R10
  one_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && adc_rdy_i |=> !adc_req_o);

  // R7
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && adc_rdy_i |-> $countones(evt_ack_o & ~clr_vec) == 1);

  // R7
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adc_req_o && adc_rdy_i) |-> (evt_ack_o & ~clr_vec) == '0);

  // R9
  no_forced_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_req_o) |-> !clr_d[sel_q]);

  // R9
  forced_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ack_o & clr_vec) == clr_vec);
endmodule

bind adc_trig_arb adc_trig_chk #(.N_EVT(N_EVT), .CH_W(CH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adc_req_o  (adc_req_o),
  .adc_rdy_i  (adc_rdy_i),
  .adc_chan_o (adc_chan_o),
  .evt_ack_o  (evt_ack_o),
  .clr_vec    (clr_vec),
  .sel_q      (sel_q)
);

// File: tb/sim_adc_trig_arb.sv
`timescale 1ns/1ps
module sim_adc_trig_arb;
  localparam int N  = 8;
  localparam int CW = 7;
  localparam int AW = $clog2(N);
  localparam logic [N-1:0] FMASK = 8'h0C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [CW:0]   reg_wdata_i = '0;
  logic [CW:0]   reg_rdata_o;
  logic [N-1:0]  evt_flag_i = '0;
  logic [N-1:0]  evt_ack_o;
  logic          adc_req_o;
  logic [CW-1:0] adc_chan_o;
  logic          adc_rdy_i = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  logic [N-1:0] exp_force = '0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  adc_trig_arb #(.N_EVT(N), .CH_W(CW), .FORCE_MASK(FMASK)) u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [CW:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = AW'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW:0] d);
    @(negedge clk_i);
    reg_addr_i = AW'(a);
    @(negedge clk_i);
    d = reg_rdata_o;
  endtask

  // wait for request, check it, accept it, optionally drop the flag at the handshake edge
  task automatic serve(input int idx, input logic [CW-1:0] ch, input bit drop, input string rq);
    logic [N-1:0] oh;
    int w = 0;
    oh = '0; oh[idx] = 1'b1;
    while (!adc_req_o && w < 20) begin @(negedge clk_i); w++; end
    chk(adc_req_o == 1'b1, rq, 32'(adc_req_o), 1);
    chk(adc_chan_o == ch, rq, 32'(adc_chan_o), 32'(ch));
    adc_rdy_i = 1'b1;
    #1;
    chk(evt_ack_o == (exp_force | oh), {rq, " R7 ack"}, 32'(evt_ack_o), 32'(exp_force | oh));
    if (drop) evt_flag_i[idx] = 1'b0;
    @(negedge clk_i);
    adc_rdy_i = 1'b0;
    chk(adc_req_o == 1'b0, "R10 bubble", 32'(adc_req_o), 0);
    chk(evt_ack_o == exp_force, "R7 pulse end", 32'(evt_ack_o), 32'(exp_force));
  endtask

  task automatic t_reset;
    logic [CW:0] d;
    chk(adc_req_o == 1'b0, "R1 req", 32'(adc_req_o), 0);
    chk(evt_ack_o == '0, "R1 ack", 32'(evt_ack_o), 0);
    for (int i = 0; i < N; i++) begin
      rd(i, d);
      chk(d == '0, "R1 cfg", 32'(d), 0);
    end
  endtask

  task automatic t_regs;
    logic [CW:0] d;
    for (int i = 0; i < N; i++) wr(i, (CW+1)'(7'h10 + i));
    for (int i = N - 1; i >= 0; i--) begin
      rd(i, d);
      chk(d == (CW+1)'(7'h10 + i), "R2 readback", 32'(d), 32'(7'h10 + i));
    end
    wr(5, 8'h7F);
    rd(5, d);
    chk(d == 8'h7F, "R2 full field", 32'(d), 32'h7F);
    wr(5, 8'h15);
  endtask

  task automatic t_prio;
    @(negedge clk_i);
    evt_flag_i = 8'b0101_0010;
    @(negedge clk_i);
    chk(adc_req_o && adc_chan_o == 7'h11, "R4 lowest first", 32'(adc_chan_o), 32'h11);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(adc_req_o && adc_chan_o == 7'h11, "R6 hold", 32'(adc_chan_o), 32'h11);
    end
    serve(1, 7'h11, 1, "R4 idx1");
    serve(4, 7'h14, 1, "R5 idx4");
    serve(6, 7'h16, 1, "R5 idx6");
    @(negedge clk_i);
    chk(adc_req_o == 1'b0, "R4 drained", 32'(adc_req_o), 0);
  endtask

  task automatic t_repeat;
    @(negedge clk_i);
    evt_flag_i[3] = 1'b1;
    serve(3, 7'h13, 0, "R8 first");
    serve(3, 7'h13, 1, "R8 again");
    @(negedge clk_i);
    chk(adc_req_o == 1'b0, "R8 done", 32'(adc_req_o), 0);
  endtask

  task automatic t_force;
    logic [CW:0] d;
    wr(2, 8'h92);
    exp_force[2] = 1'b1;
    rd(2, d);
    chk(d == 8'h92, "R3 force stored", 32'(d), 32'h92);
    chk(evt_ack_o == 8'h04, "R9 forced ack", 32'(evt_ack_o), 32'h04);
    evt_flag_i = 8'b0010_0100;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(evt_ack_o[2] == 1'b1, "R9 ack held", 32'(evt_ack_o), 32'h04);
    end
    serve(5, 7'h15, 1, "R9 skip forced");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(adc_req_o == 1'b0, "R9 never granted", 32'(adc_req_o), 0);
    end
    wr(0, 8'h80 | 8'h30);
    rd(0, d);
    chk(d == 8'h30, "R3 no force bit", 32'(d), 32'h30);
    chk(evt_ack_o == 8'h04, "R3 no force ack", 32'(evt_ack_o), 32'h04);
    evt_flag_i[0] = 1'b1;
    serve(0, 7'h30, 1, "R3 still arbitrated");
    evt_flag_i = '0;
    wr(2, 8'h12);
    exp_force = '0;
    @(negedge clk_i);
    chk(evt_ack_o == '0, "R9 force off", 32'(evt_ack_o), 0);
  endtask

  task automatic t_latch;
    wr(7, 8'h21);
    evt_flag_i[7] = 1'b1;
    @(negedge clk_i);
    chk(adc_req_o && adc_chan_o == 7'h21, "R11 grant", 32'(adc_chan_o), 32'h21);
    wr(7, 8'h55);
    chk(adc_req_o && adc_chan_o == 7'h21, "R11 latched", 32'(adc_chan_o), 32'h21);
    serve(7, 7'h21, 1, "R11 serve");
    evt_flag_i[7] = 1'b1;
    serve(7, 7'h55, 1, "R11 new value");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_prio();
    t_repeat();
    t_force();
    t_latch();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule